// File: doc/BRIEF.md
# Modulo-6 Counter with Held Carry

This block counts from 0 up to 5 and then wraps to 0, advancing on a rising clock edge only when its step-enable input is high. When the enable is low, the count and the carry are left as they are.

The carry output is not a one-cycle terminal-count pulse. It rises when the count wraps from 5 to 0. It stays high for as long as the count rests at 0, and it drops on the step from 0 to 1. The state register therefore holds a carry bit next to the count. This lets a 0 reached by reset (carry low) be told apart from a 0 reached by a wrap (carry high).

A parameter picks one of two output styles, and both use the same next-state logic. In the registered (Moore) style, the outputs are the present state. In the look-ahead (Mealy) style, the outputs are a function of the present state and the enable: they show the values the state will take at the coming edge. The reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `mod6_carry_counter`

## Requirements
- R1: While the reset input is low, count_o reads 0 and carry_o reads 0 in both styles, and they take these values as soon as the reset input falls, without waiting for a clock edge.
- R2: With step_en_i high and the count at a value from 0 to 4, the registered count rises by exactly one at the clock edge.
- R3: With step_en_i low, a clock edge leaves both the count and the carry unchanged, whatever their values.
- R4: With step_en_i high and the count at 5, the count becomes 0 at the clock edge. The count never shows 6 or 7.
- R5: The 5-to-0 wrap sets carry_o to 1 in the same edge that the count returns to 0.
- R6: After a wrap, carry_o stays 1 for as many edges as step_en_i stays low while the count rests at 0.
- R7: The step from 0 to 1 clears carry_o, and carry_o is 0 whenever the count is anywhere from 1 to 5.
- R8: A count of 0 reached through reset shows carry_o equal to 0.
- R9: In the look-ahead style (OUT_STYLE = STYLE_MEALY), outside reset, count_o and carry_o equal the count and carry that the register will hold after the coming edge for the present step_en_i, so they change when step_en_i changes between edges.
- R10: In the registered style (OUT_STYLE = STYLE_MOORE), count_o and carry_o change only at clock edges or on reset. A change of step_en_i between edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| step_en_i | input | 1 | 1: advance the count at the edge; 0: hold |
| count_o | output | CNT_W (3) | Present count, or next count in the look-ahead style |
| carry_o | output | 1 | Held carry: set on the 5-to-0 wrap, cleared on the 0-to-1 step |

## Verification
The bench focuses on the edges of the carry's life. It checks the wrap edge, where a design that pulsed the carry for one cycle would drop it during the following holds at 0. It checks the 0-to-1 step, where a design that cleared the carry on any edge, or never cleared it, would show a wrong value at count 1. It also checks a reset that lands while the carry is set, where a design that keyed the carry on the count alone would report a carry at the reset 0. Both output styles run side by side on the same stimulus. Toggling the enable between edges exposes a look-ahead output that lags a cycle, and a registered output that leaks the input through.

// File: rtl/m6_pkg.sv
package m6_pkg;

  typedef enum logic {
    STYLE_MOORE = 1'b0,
    STYLE_MEALY = 1'b1
  } out_style_e;

endpackage

// File: rtl/m6_rst_sync.sv
module m6_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/m6_next_state.sv
module m6_next_state #(
  parameter int CNT_W  = 3,
  parameter int MODULO = 6
) (
  input  logic [CNT_W-1:0] cur_cnt_i,
  input  logic             cur_carry_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] nxt_cnt_o,
  output logic             nxt_carry_o
);

  localparam logic [CNT_W:0]   MOD_L  = (CNT_W+1)'(MODULO);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(MODULO - 1);

  logic [CNT_W-1:0] step_cnt;
  logic             valid;
  logic             wrap;
  logic             leave_zero;

  assign valid = ({1'b0, cur_cnt_i} < MOD_L);

  generate
    if (CNT_W == 3 && MODULO == 6) begin : g_gates
      // Reduced sum-of-products for the six-state sequence.
      assign step_cnt[2] = (cur_cnt_i[2] & ~cur_cnt_i[0])
                         | (cur_cnt_i[2] & ~en_i)
                         | (cur_cnt_i[1] & cur_cnt_i[0] & en_i);
      assign step_cnt[1] = (cur_cnt_i[1] & ~cur_cnt_i[0])
                         | (cur_cnt_i[1] & ~en_i)
                         | (~cur_cnt_i[2] & ~cur_cnt_i[1] & cur_cnt_i[0] & en_i);
      assign step_cnt[0] = cur_cnt_i[0] ^ en_i;
    end else begin : g_arith
      always_comb begin
        if (!en_i) begin
          step_cnt = cur_cnt_i;
        end else if (cur_cnt_i == LAST_L) begin
          step_cnt = '0;
        end else begin
          step_cnt = cur_cnt_i + 1'b1;
        end
      end
    end
  endgenerate

  assign wrap       = en_i & (cur_cnt_i == LAST_L);
  assign leave_zero = en_i & (cur_cnt_i == '0);

  always_comb begin
    if (!valid) begin
      nxt_cnt_o   = '0;
      nxt_carry_o = 1'b0;
    end else begin
      nxt_cnt_o   = step_cnt;
      nxt_carry_o = wrap | (cur_carry_i & ~leave_zero);
    end
  end

endmodule

// File: rtl/m6_out_sel.sv
module m6_out_sel #(
  parameter int                CNT_W     = 3,
  parameter m6_pkg::out_style_e OUT_STYLE = m6_pkg::STYLE_MOORE
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cur_cnt_i,
  input  logic             cur_carry_i,
  input  logic [CNT_W-1:0] nxt_cnt_i,
  input  logic             nxt_carry_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             carry_o
);

  generate
    if (OUT_STYLE == m6_pkg::STYLE_MEALY) begin : g_mealy
      assign cnt_o   = run_i ? nxt_cnt_i   : '0;
      assign carry_o = run_i ? nxt_carry_i : 1'b0;
    end else begin : g_moore
      logic unused_ok;
      assign unused_ok = run_i ^ nxt_carry_i ^ (^nxt_cnt_i);
      assign cnt_o     = cur_cnt_i;
      assign carry_o   = cur_carry_i;
    end
  endgenerate

endmodule

// File: rtl/mod6_carry_counter.sv
module mod6_carry_counter #(
  parameter int                 CNT_W     = 3,
  parameter int                 MODULO    = 6,
  parameter m6_pkg::out_style_e OUT_STYLE = m6_pkg::STYLE_MOORE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_o
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             carry_q;
  logic             carry_d;

  m6_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  m6_next_state #(.CNT_W(CNT_W), .MODULO(MODULO)) u_next (
    .cur_cnt_i   (cnt_q),
    .cur_carry_i (carry_q),
    .en_i        (step_en_i),
    .nxt_cnt_o   (cnt_d),
    .nxt_carry_o (carry_d)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      carry_q <= carry_d;
    end
  end

  m6_out_sel #(.CNT_W(CNT_W), .OUT_STYLE(OUT_STYLE)) u_out (
    .run_i       (rst_sync_n),
    .cur_cnt_i   (cnt_q),
    .cur_carry_i (carry_q),
    .nxt_cnt_i   (cnt_d),
    .nxt_carry_i (carry_d),
    .cnt_o       (count_o),
    .carry_o     (carry_o)
  );

endmodule

// File: rtl/mod6_carry_counter_chk.sv
module mod6_carry_counter_chk #(
  parameter int CNT_W  = 3,
  parameter int MODULO = 6
) (
  input logic             clk_i,
  input logic             rst_sync_n,
  input logic             en,
  input logic [CNT_W-1:0] cnt_q,
  input logic             carry_q
);

  localparam logic [CNT_W:0]   MOD_L  = (CNT_W+1)'(MODULO);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(MODULO - 1);

  a_r4_in_range: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ({1'b0, cnt_q} < MOD_L));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (en && cnt_q != LAST_L) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!en) |=> ($stable(cnt_q) && $stable(carry_q)));

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (en && cnt_q == LAST_L) |=> (cnt_q == '0 && carry_q));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (en && cnt_q == '0) |=> (!carry_q));

  a_r7_zero_only: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    carry_q |-> (cnt_q == '0));

endmodule

bind mod6_carry_counter mod6_carry_counter_chk #(.CNT_W(CNT_W), .MODULO(MODULO)) u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .en         (step_en_i),
  .cnt_q      (cnt_q),
  .carry_q    (carry_q)
);

// File: tb/mod6_carry_counter_test.sv
`timescale 1ns/1ps
module mod6_carry_counter_test;

  typedef struct {
    logic [2:0] cnt;
    logic       carry;
    string      req;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [2:0] cnt_moore;
  logic       carry_moore;
  logic [2:0] cnt_mealy;
  logic       carry_mealy;

  int errors = 0;
  int checks = 0;
  item_t sb_q[$];

  logic [2:0] m_cnt;
  logic       m_carry;

  mod6_carry_counter #(.OUT_STYLE(m6_pkg::STYLE_MOORE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .step_en_i(en),
    .count_o(cnt_moore), .carry_o(carry_moore));

  mod6_carry_counter #(.OUT_STYLE(m6_pkg::STYLE_MEALY)) uut_mealy (
    .clk_i(clk), .rst_ni(rst_n), .step_en_i(en),
    .count_o(cnt_mealy), .carry_o(carry_mealy));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [2:0] c_act, input logic k_act,
                       input logic [2:0] c_exp, input logic k_exp);
    checks++;
    if (c_act !== c_exp || k_act !== k_exp) begin
      errors++;
      $display("FAIL %s: count=%0d carry=%0b expected count=%0d carry=%0b",
               req, c_act, k_act, c_exp, k_exp);
    end
  endtask

  // Driver: apply enable, check look-ahead and registered outputs mid-cycle,
  // then queue the expected registered result of the edge.
  task automatic step(input logic u);
    logic [2:0] n_cnt;
    logic       n_carry;
    string      req;
    @(negedge clk);
    en = u;
    #1;
    if (!u) begin
      n_cnt = m_cnt; n_carry = m_carry;
      req = (m_cnt == 3'd0 && m_carry) ? "R6" : "R3";
    end else if (m_cnt == 3'd5) begin
      n_cnt = 3'd0; n_carry = 1'b1; req = "R5";
    end else if (m_cnt == 3'd0) begin
      n_cnt = 3'd1; n_carry = 1'b0; req = m_carry ? "R7" : "R2";
    end else begin
      n_cnt = m_cnt + 3'd1; n_carry = 1'b0; req = (m_cnt == 3'd4) ? "R4" : "R2";
    end
    check("R9", cnt_mealy, carry_mealy, n_cnt, n_carry);
    check("R10", cnt_moore, carry_moore, m_cnt, m_carry);
    @(posedge clk);
    m_cnt = n_cnt; m_carry = n_carry;
    sb_q.push_back('{cnt: n_cnt, carry: n_carry, req: req});
  endtask

  // Monitor: compare registered outputs against the queue.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.req, cnt_moore, carry_moore, it.cnt, it.carry);
    end
  end

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; m_cnt = 3'd0; m_carry = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", cnt_moore, carry_moore, 3'd0, 1'b0);
    check("R1", cnt_mealy, carry_mealy, 3'd0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(1'b0);
    check("R8", cnt_moore, carry_moore, 3'd0, 1'b0);

    for (int i = 0; i < 6; i++) step(1'b1);   // R2, R4, R5 wrap
    repeat (3) step(1'b0);                    // R6 held carry
    step(1'b1);                               // R7 clear
    step(1'b1);
    step(1'b0);                               // R3 hold mid count
    step(1'b1);
    step(1'b0);
    for (int i = 0; i < 3; i++) step(1'b1);   // reach 5 then wrap
    step(1'b0);

    // Toggle enable between edges: registered output must not follow (R10).
    @(negedge clk); en = 1'b1; #1; en = 1'b0; #1;
    check("R10", cnt_moore, carry_moore, m_cnt, m_carry);
    check("R9", cnt_mealy, carry_mealy, m_cnt, m_carry);

    // Mid-run reset while carry is set: immediate clear (R1), zero carry (R8).
    @(negedge clk); #2;
    rst_n = 1'b0;
    #1;
    check("R1", cnt_moore, carry_moore, 3'd0, 1'b0);
    check("R1", cnt_mealy, carry_mealy, 3'd0, 1'b0);
    m_cnt = 3'd0; m_carry = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(1'b0);
    check("R8", cnt_moore, carry_moore, 3'd0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b1);
    step(1'b0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule